// File: doc/BRIEF.md
# Program-Erase Pulse Limit Monitor

This block models, at the device level, how a flash memory's internal program and erase engine detects failure. It holds a small word array. A program operation applies write pulses to one word and checks the word after each one. An erase operation sets every word of the array back to all ones, one word per pulse. Each operation counts its pulses, and the count starts again at zero when a new operation begins. If the number of pulses reaches the configured limit before the operation completes, the engine stops in a failed state and reports failure in bit 5 of its status word.

A program pulse can only clear bits: it writes `stored & data`. A request that needs a 0 to become 1 therefore never passes its check and always runs into the limit. Only an erase brings ones back. While an operation is running or has failed, a read returns a status word instead of array data. Bit 6 of that word changes on every status read. The failed state stays until the host issues the reset command. After that, reads return array data again.

Top module: `pulse_limit_monitor`

## Requirements
- R1: An erase command (`cmd_op` = 1) writes all ones to every word of the array, and `busy` then returns low.
- R2: A program command (`cmd_op` = 0) stores the bitwise AND of the old word and `cmd_data` at `cmd_addr`, and leaves every other word unchanged.
- R3: A program request that needs any bit to go from 0 to 1 leaves the word equal to the AND of old and new, and ends failed: status bit 5 reads 1.
- R4: Failure is entered exactly when LIMIT pulses have been applied without the operation completing. The pulse count restarts at every accepted program or erase, so a later good operation does not fail.
- R5: While `busy` is high, a read returns a status word. Bit 6 inverts on each successive status read, starting from 0 after reset. Bit 5 is the failure flag. All other bits are 0.
- R6: The failed state is sticky. `busy` stays high, no array word is written, and program or erase commands are ignored until the reset command arrives.
- R7: A reset command (`cmd_op` = 2) in the failed state returns the block to idle (`busy` low). Later reads then return array data.
- R8: `busy` is high while a program or erase runs, and any command received during that time is ignored.
- R9: In idle, a read request returns the word stored at `rd_addr` on `rd_data`, with `rd_valid` high, one cycle after the request.
- R10: After programming has cleared bits, an erase restores them to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 program, 1 erase, 2 reset, 3 no operation |
| cmd_addr | input | AW | Word address for program |
| cmd_data | input | DW | Data for program |
| rd_req | input | 1 | Read request |
| rd_addr | input | AW | Read word address |
| rd_valid | output | 1 | Read data valid, one cycle after request |
| rd_data | output | DW | Array word or status word |
| busy | output | 1 | Operation running or failed |

## Verification
On every cycle, the assertions check the following:
- no program write ever sets a bit that the array held at 0, using a shadow copy of the array;
- failure rises only when the independently counted number of pulses equals the limit;
- the failed state holds and writes nothing until a reset command, and that command clears it;
- successive status reads alternate bit 6.

Only the bench scenarios can show whether the array contents are right after each operation, whether commands during an operation are really ignored, whether a failed word keeps its partly cleared value across an ignored erase, and whether erase brings cleared bits back.

// File: rtl/plm_pkg.sv
package plm_pkg;
  typedef enum logic [1:0] {
    CMD_PROG  = 2'd0,
    CMD_ERASE = 2'd1,
    CMD_RESET = 2'd2,
    CMD_NOP   = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PULSE,
    ST_CHECK,
    ST_ERASE,
    ST_FAIL
  } state_e;

  localparam int TOG_BIT  = 6;
  localparam int FAIL_BIT = 5;
endpackage

// File: rtl/plm_ram.sv
module plm_ram #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/plm_engine.sv
module plm_engine #(
  parameter int DW    = 8,
  parameter int AW    = 3,
  parameter int LIMIT = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic [DW-1:0] ram_q,
  output logic          ram_re,
  output logic [AW-1:0] ram_raddr,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [DW-1:0] ram_wdata,
  output logic          busy,
  output logic          fail,
  output logic          pgm_active
);
  import plm_pkg::*;

  localparam int CW = $clog2(LIMIT + 2);
  localparam logic [AW-1:0] LAST = AW'((1 << AW) - 1);

  state_e        st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] ptr;
  logic [DW-1:0] data_q;
  logic [DW-1:0] word_q;

  always_comb begin
    ram_re    = (st == ST_LOAD);
    ram_raddr = addr_q;
    ram_we    = (st == ST_PULSE) || (st == ST_ERASE);
    ram_waddr = (st == ST_ERASE) ? ptr : addr_q;
    ram_wdata = (st == ST_ERASE) ? '1 : (ram_q & data_q);
  end

  assign busy       = (st != ST_IDLE);
  assign fail       = (st == ST_FAIL);
  assign pgm_active = (st == ST_LOAD) || (st == ST_PULSE) || (st == ST_CHECK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      ptr    <= '0;
      addr_q <= '0;
      data_q <= '0;
      word_q <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (cmd_valid && cmd_op == CMD_PROG) begin
            addr_q <= cmd_addr;
            data_q <= cmd_data;
            cnt    <= '0;
            st     <= ST_LOAD;
          end else if (cmd_valid && cmd_op == CMD_ERASE) begin
            ptr <= '0;
            cnt <= '0;
            st  <= ST_ERASE;
          end
        end
        ST_LOAD:  st <= ST_PULSE;
        ST_PULSE: begin
          word_q <= ram_q & data_q;
          cnt    <= cnt + 1'b1;
          st     <= ST_CHECK;
        end
        ST_CHECK: begin
          if (word_q == data_q)              st <= ST_IDLE;
          else if (int'(cnt) >= LIMIT)       st <= ST_FAIL;
          else                               st <= ST_LOAD;
        end
        ST_ERASE: begin
          cnt <= cnt + 1'b1;
          ptr <= ptr + 1'b1;
          if (ptr == LAST)                   st <= ST_IDLE;
          else if (int'(cnt) + 1 >= LIMIT)   st <= ST_FAIL;
        end
        ST_FAIL: begin
          if (cmd_valid && cmd_op == CMD_RESET) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/plm_status.sv
module plm_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req,
  input  logic          busy,
  input  logic          fail,
  output logic          rd_valid,
  output logic          is_stat,
  output logic [DW-1:0] stat_word
);
  import plm_pkg::*;

  logic          tog;
  logic [DW-1:0] next_word;

  always_comb begin
    next_word           = '0;
    next_word[TOG_BIT]  = tog;
    next_word[FAIL_BIT] = fail;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      is_stat   <= 1'b0;
      stat_word <= '0;
      tog       <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        is_stat <= busy;
        if (busy) begin
          stat_word <= next_word;
          tog       <= ~tog;
        end
      end
    end
  end
endmodule

// File: rtl/pulse_limit_monitor.sv
module pulse_limit_monitor #(
  parameter int DW    = 8,
  parameter int AW    = 3,
  parameter int LIMIT = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  logic          eng_re;
  logic [AW-1:0] eng_raddr;
  logic          ram_we;
  logic [AW-1:0] ram_waddr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_q;
  logic          eng_fail;
  logic          eng_pgm;
  logic          is_stat;
  logic [DW-1:0] stat_word;

  plm_engine #(.DW(DW), .AW(AW), .LIMIT(LIMIT)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .ram_q      (ram_q),
    .ram_re     (eng_re),
    .ram_raddr  (eng_raddr),
    .ram_we     (ram_we),
    .ram_waddr  (ram_waddr),
    .ram_wdata  (ram_wdata),
    .busy       (busy),
    .fail       (eng_fail),
    .pgm_active (eng_pgm)
  );

  plm_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (busy ? eng_re : rd_req),
    .raddr (busy ? eng_raddr : rd_addr),
    .q     (ram_q)
  );

  plm_status #(.DW(DW)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .busy      (busy),
    .fail      (eng_fail),
    .rd_valid  (rd_valid),
    .is_stat   (is_stat),
    .stat_word (stat_word)
  );

  assign rd_data = is_stat ? stat_word : ram_q;
endmodule

// File: rtl/plm_checker.sv
module plm_checker #(
  parameter int DW    = 8,
  parameter int AW    = 3,
  parameter int LIMIT = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic          busy,
  input logic          fail,
  input logic          ram_we,
  input logic [AW-1:0] ram_waddr,
  input logic [DW-1:0] ram_wdata,
  input logic          pgm_active,
  input logic          rd_valid,
  input logic          is_stat,
  input logic          stat_tog
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = $clog2(LIMIT + DEPTH + 2);

  logic [DW-1:0]    shadow [DEPTH];
  logic [DEPTH-1:0] known;
  logic [PW-1:0]    pcnt;
  logic             last_tog;
  logic             have_prev;
  logic             accept;

  assign accept = cmd_valid && !busy && (cmd_op == 2'd0 || cmd_op == 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      known     <= '0;
      pcnt      <= '0;
      last_tog  <= 1'b0;
      have_prev <= 1'b0;
    end else begin
      if (ram_we) begin
        shadow[ram_waddr] <= ram_wdata;
        known[ram_waddr]  <= 1'b1;
      end
      if (accept)      pcnt <= '0;
      else if (ram_we) pcnt <= pcnt + 1'b1;
      if (rd_valid && is_stat) begin
        last_tog  <= stat_tog;
        have_prev <= 1'b1;
      end
    end
  end

  AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ram_we && pgm_active && known[ram_waddr]) |-> ((ram_wdata & ~shadow[ram_waddr]) == '0)); // R2
  AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> (int'(pcnt) == LIMIT)); // R4
  AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (fail && !(cmd_valid && cmd_op == 2'd2)) |=> fail); // R6
  AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    fail |-> !ram_we); // R6
  AST_RESET_CMD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (fail && cmd_valid && cmd_op == 2'd2) |=> (!busy && !fail)); // R7
  AST_TOGGLE_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && is_stat && have_prev) |-> (stat_tog != last_tog)); // R5
endmodule

bind pulse_limit_monitor plm_checker #(.DW(DW), .AW(AW), .LIMIT(LIMIT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .busy       (busy),
  .fail       (eng_fail),
  .ram_we     (ram_we),
  .ram_waddr  (ram_waddr),
  .ram_wdata  (ram_wdata),
  .pgm_active (eng_pgm),
  .rd_valid   (rd_valid),
  .is_stat    (is_stat),
  .stat_tog   (rd_data[plm_pkg::TOG_BIT])
);

// File: tb/tb_pulse_limit_monitor.sv
module tb_pulse_limit_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int LIMIT = 12;
  localparam logic [1:0] OP_PROG  = 2'd0;
  localparam logic [1:0] OP_ERASE = 2'd1;
  localparam logic [1:0] OP_RESET = 2'd2;

  logic          clk = 1'b0;
  logic          rst;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          busy;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } item_t;

  item_t sbq[$];
  int    checks = 0;
  int    errors = 0;
  logic  tb_tog = 1'b0;

  pulse_limit_monitor #(.DW(DW), .AW(AW), .LIMIT(LIMIT)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd3;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    rd_req = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic rd_stat(input logic fail_exp, input string tag);
    logic [DW-1:0] e;
    e = '0;
    e[6] = tb_tog;
    e[5] = fail_exp;
    tb_tog = ~tb_tog;
    rd(0, e, tag);
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(tag, DW'(busy), '0);
  endtask

  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (sbq.size() == 0) begin
        chk("R9 unexpected rd_valid", 8'h01, 8'h00);
      end else begin
        item_t it;
        it = sbq.pop_front();
        chk(it.tag, rd_data, it.exp);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'd3; cmd_addr = '0; cmd_data = '0;
    rd_req = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    chk("R7 reset busy", DW'(busy), '0);
    chk("R9 reset rd_valid", DW'(rd_valid), '0);
    rst = 1'b0;
    @(negedge clk);

    // Erase, status toggling while running, program ignored during erase
    send(OP_ERASE, 0, 0);
    chk("R8 busy during erase", DW'(busy), 8'h01);
    rd_stat(1'b0, "R5 status read 1");
    rd_stat(1'b0, "R5 status read 2");
    send(OP_PROG, 2, 8'h00);
    wait_idle("R1 erase completes");
    for (int a = 0; a < 8; a++) rd(AW'(a), 8'hFF, "R1 erased word");
    rd(2, 8'hFF, "R8 program during erase ignored");

    // Programming only clears bits
    send(OP_PROG, 3, 8'hA5);
    wait_idle("R2 program completes");
    rd(3, 8'hA5, "R2 first program");
    send(OP_PROG, 3, 8'h05);
    wait_idle("R2 second program");
    rd(3, 8'h05, "R2 clear more bits");
    rd(4, 8'hFF, "R2 neighbour untouched");
    rd(3, 8'h05, "R9 idle read latency");

    // Program 1 over 0: fails at the limit
    send(OP_PROG, 3, 8'hF5);
    rd_stat(1'b0, "R4 no failure before limit");
    repeat (60) @(negedge clk);
    chk("R6 busy held in failure", DW'(busy), 8'h01);
    rd_stat(1'b1, "R3 failure flag");
    rd_stat(1'b1, "R5 toggle in failure");
    send(OP_ERASE, 0, 0);
    repeat (20) @(negedge clk);
    rd_stat(1'b1, "R6 erase ignored while failed");
    send(OP_RESET, 0, 0);
    chk("R7 reset command idles", DW'(busy), '0);
    rd(3, 8'h05, "R3 word kept as AND");
    rd(3, 8'h05, "R6 erase had no effect");
    rd(5, 8'hFF, "R7 array read after reset");

    // Erase restores ones; counter starts fresh
    send(OP_ERASE, 0, 0);
    wait_idle("R1 second erase");
    rd(3, 8'hFF, "R10 ones restored");
    send(OP_PROG, 0, 8'h00);
    wait_idle("R4 fresh count program");
    rd(0, 8'h00, "R2 all zeros");
    send(OP_PROG, 7, 8'h3C);
    wait_idle("R4 fresh count second");
    rd(7, 8'h3C, "R2 pattern 3C");

    repeat (3) @(negedge clk);
    chk("R9 scoreboard drained", DW'(sbq.size()), '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule